// File: doc/BRIEF.md
# ULPI link-side bus controller

This block is the controller end of an 8-bit single-data-rate ULPI bus. It runs in the interface clock domain and shares the data lines with a PHY. The PHY owns the DIR and NXT signals. The link owns STP and, whenever the bus belongs to it, the data lines. The bidirectional data bus is split into `ulpi_data_i`, `ulpi_data_o` and an output enable, `ulpi_data_oe`. A pad wrapper joins them.

User logic reaches the bus through three ports:
- A byte-stream transmit port. The first byte of a packet carries the packet identifier in its low nibble. Each later byte is taken when `tx_ready` is high.
- A register access port. A request is held until `reg_ack` pulses.
- A receive port. It reports every byte the PHY places on the bus, and flags whether that byte is an RXCMD status byte or decoded USB data.

The block follows the direction handshake. It releases the bus on every DIR edge and drops the turnaround cycle that goes with that edge. It re-issues a command that the PHY pre-empted before accepting it.

Top module: `ulpi_link_ctrl`

## Requirements
- R1: When no transfer is active and DIR has been low for at least one full cycle, `ulpi_data_oe` is high, `ulpi_data_o` is 0x00 and `ulpi_stp` is low. This also applies in the cycle right after reset.
- R2: Every transfer opens with a non-zero command byte. The byte stays on the bus until a cycle with DIR low, no turnaround and NXT high. Its top two bits give the command type. Its low six bits are the register address, or for a transmit two zero bits followed by the packet identifier. The encodings are: transmit `{01,00,pid[3:0]}`, register write `{10,addr}`, register read `{11,addr}`.
- R3: A cycle in which DIR differs from its value in the previous cycle is a turnaround. In that cycle `ulpi_data_oe` is low and no receive byte is reported for it. While DIR is high, `ulpi_data_oe` is low.
- R4: `tx_ready` is high exactly in the cycles where the byte on the bus is accepted, meaning DIR low, no turnaround and NXT high. The next packet byte appears on `ulpi_data_o` in the following cycle.
- R5: In the cycle after the last packet byte is accepted, `ulpi_stp` is high for exactly one cycle with `ulpi_data_o` at 0x00. The bus then returns to the idle state of R1.
- R6: For every cycle with DIR high and no turnaround, other than a read-data cycle, the next cycle shows `rx_valid` high. In that cycle `rx_data` equals the bus byte and `rx_cmd` equals the inverse of NXT (1 = RXCMD, 0 = USB data).
- R7: For a register write, the write data is driven in the cycle after the command is accepted. `ulpi_stp` is pulsed in the cycle after the data is accepted. `reg_ack` is high for one cycle after the STP cycle.
- R8: For a register read, the command is accepted and the PHY's turnaround passes. The first later cycle with DIR high and NXT low is then captured into `reg_rdata`. `reg_ack` is high for one cycle after that capture, and the byte is not reported on the receive port.
- R9: If DIR rises while a command is pending and not yet accepted, the command is not accepted. The bytes that arrive are received as in R6. The same command is driven again in the first cycle after the turnaround that follows DIR falling.
- R10: When a register request and a transmit request are both waiting in idle, the register command is issued first. A register request still high in the cycle `reg_ack` is high does not start a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ulpi_dir | input | 1 | Bus direction from the PHY (1 = PHY drives) |
| ulpi_nxt | input | 1 | Throttle / data marker from the PHY |
| ulpi_data_i | input | 8 | Data lines as seen at the pad |
| ulpi_data_o | output | 8 | Data the link drives |
| ulpi_data_oe | output | 1 | Link output enable for the data lines |
| ulpi_stp | output | 1 | Stop strobe to the PHY |
| tx_valid | input | 1 | Packet byte available |
| tx_data | input | 8 | Packet byte (first byte: identifier in low nibble) |
| tx_last | input | 1 | Current byte is the last of the packet |
| tx_ready | output | 1 | Current packet byte accepted this cycle |
| rx_valid | output | 1 | Received byte valid |
| rx_cmd | output | 1 | Received byte is an RXCMD status byte |
| rx_data | output | 8 | Received byte |
| reg_req | input | 1 | Register access request, held until acknowledge |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_ack | output | 1 | One-cycle access completion |
| reg_rdata | output | 8 | Register read data, valid with `reg_ack` |

## Verification
The bench builds the block with its default 8-bit data width. That width gives a 6-bit address field and a 4-bit identifier field, so all three command types and their exact byte encodings can be compared at the pins. A scripted PHY drives DIR and NXT through throttled transmits, receive bursts mixing status and data bytes, and register reads with both turnarounds. It also raises DIR in front of a pending command and issues a register request and a transmit together. Throughout, a monitor watches for the link driving the lines during a turnaround or while the PHY owns the bus.

// File: rtl/ulpi_link_pkg.sv
package ulpi_link_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_TDATA,
        ST_WDATA,
        ST_STP,
        ST_RTURN,
        ST_RDATA
    } lk_state_e;

    // top two bits of every command byte
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_TX   = 2'b01,
        OP_WR   = 2'b10,
        OP_RD   = 2'b11
    } lk_op_e;

    localparam int unsigned OP_W = 2;

endpackage

// File: rtl/ulpi_dir_track.sv
module ulpi_dir_track (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dir_i,
    output logic turn_o,
    output logic link_owns_o,
    output logic phy_valid_o
);

    logic dir_d, dir_q;

    always_comb begin
        dir_d       = dir_i;
        turn_o      = dir_i ^ dir_q;
        link_owns_o = !dir_i && !turn_o;
        phy_valid_o = dir_i && !turn_o;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) dir_q <= 1'b0;
        else         dir_q <= dir_d;
    end

    // R3
    turn_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dir_i != $past(dir_i)) |-> !link_owns_o && !phy_valid_o);

endmodule

// File: rtl/ulpi_rx_sort.sv
module ulpi_rx_sort #(
    parameter int unsigned DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          phy_valid_i,
    input  logic          nxt_i,
    input  logic [DW-1:0] data_i,
    input  logic          suppress_i,
    output logic          rx_valid_o,
    output logic          rx_cmd_o,
    output logic [DW-1:0] rx_data_o
);

    typedef struct packed {
        logic          valid;
        logic          cmd;
        logic [DW-1:0] data;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = phy_valid_i && !suppress_i;
        if (phy_valid_i) begin
            rx_d.cmd  = !nxt_i;
            rx_d.data = data_i;
        end
        rx_valid_o = rx_q.valid;
        rx_cmd_o   = rx_q.cmd;
        rx_data_o  = rx_q.data;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rx_q <= '{valid: 1'b0, cmd: 1'b0, data: '0};
        else         rx_q <= rx_d;
    end

    // R6
    rx_after_phy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |-> $past(phy_valid_i) && !$past(suppress_i));

    // R6
    rx_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |-> (rx_cmd_o == !$past(nxt_i)));

endmodule

// File: rtl/ulpi_tx_seq.sv
module ulpi_tx_seq
    import ulpi_link_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dir_i,
    input  logic             turn_i,
    input  logic             link_owns_i,
    input  logic             phy_valid_i,
    input  logic             nxt_i,
    input  logic [DW-1:0]    bus_i,
    input  logic             tx_valid_i,
    input  logic [DW-1:0]    tx_data_i,
    input  logic             tx_last_i,
    output logic             tx_ready_o,
    input  logic             reg_req_i,
    input  logic             reg_wr_i,
    input  logic [DW-OP_W-1:0] reg_addr_i,
    input  logic [DW-1:0]    reg_wdata_i,
    output logic             reg_ack_o,
    output logic [DW-1:0]    reg_rdata_o,
    output logic [DW-1:0]    bus_o,
    output logic             stp_o,
    output logic             rd_capture_o
);

    localparam int unsigned AW    = DW - OP_W;
    localparam int unsigned PID_W = DW / 2;
    localparam int unsigned PAD_W = AW - PID_W;

    typedef struct packed {
        lk_state_e     st;
        lk_op_e        op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          ack;
        logic [DW-1:0] rdata;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_IDLE, op: OP_NONE, addr: '0,
                                 wdata: '0, ack: 1'b0, rdata: '0};

    seq_t s_d, s_q;
    logic accept;
    logic [DW-1:0] cmd_byte;

    always_comb begin
        s_d          = s_q;
        s_d.ack      = 1'b0;
        accept       = link_owns_i && nxt_i;
        tx_ready_o   = 1'b0;
        rd_capture_o = 1'b0;
        stp_o        = 1'b0;
        bus_o        = '0;

        if (s_q.op == OP_TX)
            cmd_byte = {OP_TX, {PAD_W{1'b0}}, tx_data_i[PID_W-1:0]};
        else
            cmd_byte = {s_q.op, s_q.addr};

        unique case (s_q.st)
            ST_IDLE: begin
                if (reg_req_i && !s_q.ack) begin
                    s_d.op    = reg_wr_i ? OP_WR : OP_RD;
                    s_d.addr  = reg_addr_i;
                    s_d.wdata = reg_wdata_i;
                    s_d.st    = ST_CMD;
                end else if (tx_valid_i) begin
                    s_d.op = OP_TX;
                    s_d.st = ST_CMD;
                end
            end
            ST_CMD: begin
                bus_o = cmd_byte;
                if (accept) begin
                    unique case (s_q.op)
                        OP_TX: begin
                            if (tx_valid_i) begin
                                tx_ready_o = 1'b1;
                                s_d.st     = tx_last_i ? ST_STP : ST_TDATA;
                            end
                        end
                        OP_WR:   s_d.st = ST_WDATA;
                        OP_RD:   s_d.st = ST_RTURN;
                        default: s_d.st = ST_IDLE;
                    endcase
                end
            end
            ST_TDATA: begin
                bus_o = tx_data_i;
                if (accept && tx_valid_i) begin
                    tx_ready_o = 1'b1;
                    if (tx_last_i) s_d.st = ST_STP;
                end
            end
            ST_WDATA: begin
                bus_o = s_q.wdata;
                if (accept) s_d.st = ST_STP;
            end
            ST_STP: begin
                stp_o   = 1'b1;
                s_d.st  = ST_IDLE;
                s_d.ack = (s_q.op == OP_WR);
            end
            ST_RTURN: begin
                if (dir_i && turn_i) s_d.st = ST_RDATA;
            end
            ST_RDATA: begin
                if (phy_valid_i && !nxt_i) begin
                    rd_capture_o = 1'b1;
                    s_d.rdata    = bus_i;
                    s_d.ack      = 1'b1;
                    s_d.st       = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        reg_ack_o   = s_q.ack;
        reg_rdata_o = s_q.rdata;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= SEQ_RST;
        else         s_q <= s_d;
    end

    // R2
    cmd_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == ST_CMD) |-> (bus_o != '0));

    // R4
    ready_needs_nxt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_ready_o |-> nxt_i && !dir_i && !turn_i);

    // R5
    stp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stp_o |=> !stp_o);

    // R7
    reg_ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_ack_o |=> !reg_ack_o);

    // R10
    no_restart_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_ack_o && reg_req_i) |=> (s_q.op == OP_TX) || (s_q.st == ST_IDLE));

endmodule

// File: rtl/ulpi_link_ctrl.sv
module ulpi_link_ctrl #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ulpi_dir,
    input  logic          ulpi_nxt,
    input  logic [DW-1:0] ulpi_data_i,
    output logic [DW-1:0] ulpi_data_o,
    output logic          ulpi_data_oe,
    output logic          ulpi_stp,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_last,
    output logic          tx_ready,
    output logic          rx_valid,
    output logic          rx_cmd,
    output logic [DW-1:0] rx_data,
    input  logic          reg_req,
    input  logic          reg_wr,
    input  logic [DW-3:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic          reg_ack,
    output logic [DW-1:0] reg_rdata
);

    logic turn, link_owns, phy_valid, rd_capture;

    ulpi_dir_track i_dir (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .dir_i       (ulpi_dir),
        .turn_o      (turn),
        .link_owns_o (link_owns),
        .phy_valid_o (phy_valid)
    );

    ulpi_tx_seq #(.DW(DW)) i_seq (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .dir_i        (ulpi_dir),
        .turn_i       (turn),
        .link_owns_i  (link_owns),
        .phy_valid_i  (phy_valid),
        .nxt_i        (ulpi_nxt),
        .bus_i        (ulpi_data_i),
        .tx_valid_i   (tx_valid),
        .tx_data_i    (tx_data),
        .tx_last_i    (tx_last),
        .tx_ready_o   (tx_ready),
        .reg_req_i    (reg_req),
        .reg_wr_i     (reg_wr),
        .reg_addr_i   (reg_addr),
        .reg_wdata_i  (reg_wdata),
        .reg_ack_o    (reg_ack),
        .reg_rdata_o  (reg_rdata),
        .bus_o        (ulpi_data_o),
        .stp_o        (ulpi_stp),
        .rd_capture_o (rd_capture)
    );

    ulpi_rx_sort #(.DW(DW)) i_rx (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .phy_valid_i (phy_valid),
        .nxt_i       (ulpi_nxt),
        .data_i      (ulpi_data_i),
        .suppress_i  (rd_capture),
        .rx_valid_o  (rx_valid),
        .rx_cmd_o    (rx_cmd),
        .rx_data_o   (rx_data)
    );

    assign ulpi_data_oe = link_owns;

    // R3
    no_drive_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ulpi_data_oe |-> !ulpi_dir && !$past(ulpi_dir));

    // R8
    read_not_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_capture |=> !rx_valid && reg_ack);

    // R5
    stp_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ulpi_stp |-> ulpi_data_o == '0);

endmodule

// File: tb/test_ulpi_link_ctrl.sv
module test_ulpi_link_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ulpi_dir = 1'b0, ulpi_nxt = 1'b0;
    logic [7:0] ulpi_data_i = '0;
    logic [7:0] ulpi_data_o;
    logic       ulpi_data_oe, ulpi_stp;
    logic       tx_valid = 1'b0, tx_last = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_ready, rx_valid, rx_cmd;
    logic [7:0] rx_data;
    logic       reg_req = 1'b0, reg_wr = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_ack;
    logic [7:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    logic dir_prev = 1'b0;

    always #10 clk = ~clk;

    ulpi_link_ctrl i_ulpi_link_ctrl (
        .clk(clk), .rst_n(rst_n), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
        .ulpi_data_i(ulpi_data_i), .ulpi_data_o(ulpi_data_o),
        .ulpi_data_oe(ulpi_data_oe), .ulpi_stp(ulpi_stp),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_cmd(rx_cmd),
        .rx_data(rx_data), .reg_req(reg_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
        .reg_rdata(reg_rdata)
    );

    // R3: contention monitor for the behavioural PHY
    always @(posedge clk) begin
        if (rst_n && ulpi_data_oe && (ulpi_dir || (ulpi_dir != dir_prev))) begin
            errors++;
            $display("FAIL R3 contention actual oe=1 expected oe=0 (dir=%0b prev=%0b)",
                     ulpi_dir, dir_prev);
        end
        dir_prev <= ulpi_dir;
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic phy(input logic d, input logic n, input logic [7:0] b);
        ulpi_dir = d; ulpi_nxt = n; ulpi_data_i = b;
    endtask

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick(); settle();
        chk("R1 oe", ulpi_data_oe, 1);
        chk("R1 data", ulpi_data_o, 0);
        chk("R1 stp", ulpi_stp, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 reg_ack", reg_ack, 0);
    endtask

    task automatic t_rx_burst();
        tick(); phy(1, 0, 8'h5A); settle();
        chk("R3 oe in turn", ulpi_data_oe, 0);
        tick(); phy(1, 0, 8'h2E); settle();
        chk("R3 turn not received", rx_valid, 0);
        chk("R3 oe dir high", ulpi_data_oe, 0);
        tick(); phy(1, 1, 8'hA5); settle();
        chk("R6 valid", rx_valid, 1);
        chk("R6 rxcmd flag", rx_cmd, 1);
        chk("R6 rxcmd byte", rx_data, 8'h2E);
        tick(); phy(1, 1, 8'h3C); settle();
        chk("R6 data flag", rx_cmd, 0);
        chk("R6 data byte", rx_data, 8'hA5);
        tick(); phy(0, 0, 8'h00); settle();
        chk("R6 data byte 2", rx_data, 8'h3C);
        chk("R3 oe falling turn", ulpi_data_oe, 0);
        tick(); phy(0, 0, 8'h00); settle();
        chk("R3 falling turn not received", rx_valid, 0);
        chk("R1 oe back", ulpi_data_oe, 1);
        chk("R1 idle zero", ulpi_data_o, 0);
    endtask

    task automatic t_tx_packet();
        logic [7:0] pkt [4];
        int idx = 0;
        logic [7:0] exp;
        pkt[0] = 8'hC3; pkt[1] = 8'h11; pkt[2] = 8'h22; pkt[3] = 8'h33;
        tick(); phy(0, 0, 0); tx_valid = 1; tx_data = pkt[0]; tx_last = 0; settle();
        chk("R1 still idle", ulpi_data_o, 0);
        for (int c = 0; c < 20 && idx < 4; c++) begin
            tick();
            phy(0, (c % 3) != 0, 0);
            tx_valid = 1; tx_data = pkt[idx]; tx_last = (idx == 3);
            settle();
            exp = (idx == 0) ? {2'b01, 2'b00, pkt[0][3:0]} : pkt[idx];
            chk(idx == 0 ? "R2 tx cmd" : "R4 tx byte", ulpi_data_o, exp);
            chk("R4 ready", tx_ready, ulpi_nxt);
            if (tx_ready) idx++;
        end
        chk("R4 all bytes", idx, 4);
        tick(); phy(0, 0, 0); tx_valid = 0; tx_last = 0; settle();
        chk("R5 stp", ulpi_stp, 1);
        chk("R5 stp data", ulpi_data_o, 0);
        tick(); settle();
        chk("R5 stp single", ulpi_stp, 0);
        chk("R5 idle", ulpi_data_o, 0);
    endtask

    task automatic t_regwrite(input logic [5:0] a, input logic [7:0] d);
        tick(); phy(0, 0, 0); reg_req = 1; reg_wr = 1; reg_addr = a; reg_wdata = d; settle();
        tick(); phy(0, 0, 0); settle();
        chk("R2 write cmd held", ulpi_data_o, {2'b10, a});
        tick(); phy(0, 1, 0); settle();
        chk("R2 write cmd", ulpi_data_o, {2'b10, a});
        tick(); phy(0, 1, 0); settle();
        chk("R7 write data", ulpi_data_o, d);
        chk("R7 no early stp", ulpi_stp, 0);
        tick(); phy(0, 0, 0); settle();
        chk("R7 stp", ulpi_stp, 1);
        chk("R7 no early ack", reg_ack, 0);
        tick(); settle();
        chk("R7 ack", reg_ack, 1);
        tick(); reg_req = 0; settle();
        chk("R7 ack pulse", reg_ack, 0);
        chk("R10 no restart", ulpi_data_o, 0);
    endtask

    task automatic t_regread(input logic [5:0] a, input logic [7:0] v);
        tick(); phy(0, 0, 0); reg_req = 1; reg_wr = 0; reg_addr = a; settle();
        tick(); phy(0, 1, 0); settle();
        chk("R2 read cmd", ulpi_data_o, {2'b11, a});
        tick(); phy(1, 0, 8'hFF); settle();
        chk("R3 oe read turn", ulpi_data_oe, 0);
        tick(); phy(1, 0, v); settle();
        chk("R3 oe read data", ulpi_data_oe, 0);
        tick(); phy(0, 0, 0); settle();
        chk("R8 ack", reg_ack, 1);
        chk("R8 rdata", reg_rdata, v);
        chk("R8 not on rx", rx_valid, 0);
        tick(); reg_req = 0; settle();
        chk("R8 ack pulse", reg_ack, 0);
        chk("R1 idle after read", ulpi_data_oe, 1);
    endtask

    task automatic t_abort();
        tick(); phy(0, 0, 0); tx_valid = 1; tx_data = 8'h5D; tx_last = 1; settle();
        tick(); phy(0, 0, 0); settle();
        chk("R9 cmd", ulpi_data_o, 8'h4D);
        tick(); phy(1, 1, 8'h11); settle();
        chk("R9 released", ulpi_data_oe, 0);
        chk("R9 not accepted turn", tx_ready, 0);
        tick(); phy(1, 1, 8'h77); settle();
        chk("R9 not accepted", tx_ready, 0);
        tick(); phy(0, 0, 0); settle();
        chk("R9 received", rx_valid, 1);
        chk("R9 received byte", rx_data, 8'h77);
        chk("R9 received kind", rx_cmd, 0);
        chk("R9 turn released", ulpi_data_oe, 0);
        tick(); phy(0, 0, 0); settle();
        chk("R9 retry oe", ulpi_data_oe, 1);
        chk("R9 retry cmd", ulpi_data_o, 8'h4D);
        tick(); phy(0, 1, 0); settle();
        chk("R9 accepted", tx_ready, 1);
        tick(); phy(0, 0, 0); tx_valid = 0; tx_last = 0; settle();
        chk("R5 stp after retry", ulpi_stp, 1);
        tick(); settle();
        chk("R5 stp single after retry", ulpi_stp, 0);
    endtask

    task automatic t_priority();
        tick(); phy(0, 0, 0);
        reg_req = 1; reg_wr = 1; reg_addr = 6'h07; reg_wdata = 8'h3B;
        tx_valid = 1; tx_data = 8'hA2; tx_last = 1;
        settle();
        tick(); phy(0, 1, 0); settle();
        chk("R10 register first", ulpi_data_o, 8'h87);
        chk("R10 tx waits", tx_ready, 0);
        tick(); phy(0, 1, 0); settle();
        chk("R7 write data prio", ulpi_data_o, 8'h3B);
        tick(); phy(0, 0, 0); settle();
        chk("R7 stp prio", ulpi_stp, 1);
        tick(); settle();
        chk("R7 ack prio", reg_ack, 1);
        tick(); reg_req = 0; phy(0, 1, 0); settle();
        chk("R10 tx next", ulpi_data_o, 8'h42);
        chk("R10 tx accepted", tx_ready, 1);
        tick(); phy(0, 0, 0); tx_valid = 0; tx_last = 0; settle();
        chk("R5 stp prio tx", ulpi_stp, 1);
        tick(); settle();
        chk("R5 idle prio", ulpi_stp, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_rx_burst();
        t_tx_packet();
        t_regwrite(6'h2A, 8'h96);
        t_regread(6'h15, 8'hE7);
        t_abort();
        t_priority();
        repeat (3) tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule